// File: doc/BRIEF.md
# Cascaded Sixteen-Line Interrupt Controller

This block joins two eight-line priority resolvers into one sixteen-line interrupt controller. Request lines 0 to 7 belong to the primary resolver and lines 8 to 15 to the secondary. Whenever the secondary holds a request that would win, the block forwards it into the primary on the cascade line (line 2). The processor sees a single registered interrupt level. It answers with an acknowledge strobe. One cycle later the block returns an 8-bit vector, formed from the base of the controller that supplied the request with the line number in the low three bits.

Each controller has a trigger-select register, one bit per line: 1 means level-triggered, 0 means edge-triggered. Some bits of each register can never be written. The interrupt masks, the vector bases and the end-of-interrupt strobes come from a command decoder outside this block. The block also resolves three inconsistent situations:
- a forwarded request whose source has gone away;
- an acknowledge that has nothing to acknowledge;
- a mask write that hides the request currently being signalled.

Top module: `cascade_intc`

## Requirements
- R1: After reset, `cpu_int` and `vec_valid` are 0, both trigger-select registers read 0, and no interrupt is raised while no line rises.
- R2: Request number n is line n mod 8 of controller n/8. An edge-triggered line is latched on its rising edge. It stays pending after the line falls and is cleared by its acknowledge. The lowest pending unmasked line wins. The vector is {base[4:0], line[2:0]}. A primary-line request raises `cpu_int` two clock edges after the line is first sampled high.
- R3: A level-triggered line (trigger bit 1) is pending exactly while the line is high. Acknowledging it does not clear it, so it is raised again after its end-of-interrupt if the line is still high.
- R4: A trigger-select write stores the written byte ANDed with 0xF8 for the primary and 0xDE for the secondary. The register outputs show the stored value.
- R5: A winning secondary request sets primary request 2. `cpu_int` rises three edges after the secondary line is sampled. Acknowledging it acknowledges both controllers and returns secondary base + secondary line. Input line 2 has no effect.
- R6: If primary line 2 wins while the secondary has no winner, `cpu_int` is not raised and primary request 2 is cleared, so a lower primary line is served next.
- R7: An acknowledge with no primary winner returns primary base + 7. An acknowledge whose primary winner is line 2 while the secondary has no winner returns secondary base + 7.
- R8: A mask write that masks the line currently winning drops `cpu_int` at the next edge. If that line is in the secondary, primary request 2 is also withdrawn, so a pending lower primary line is raised one edge later.
- R9: `cpu_int` is a registered level. It is 0 in the cycle after `int_ack`. `vec_valid` pulses for exactly the one cycle after each `int_ack`.
- R10: While a line is in service, that line and every lower-priority line of the same controller are not raised. A pulse on `eoi[c]` clears the highest-priority in-service line of controller c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines; bit n is request n |
| mask_we | input | 2 | Mask write strobe, bit 0 primary, bit 1 secondary |
| mask_wdata | input | 8 | New mask byte, 1 masks the line |
| trig_we | input | 2 | Trigger-select write strobe, bit 0 primary, bit 1 secondary |
| trig_wdata | input | 8 | Trigger-select byte to write |
| trig_p | output | 8 | Stored primary trigger-select value |
| trig_s | output | 8 | Stored secondary trigger-select value |
| base_p | input | 5 | Primary vector base, vector bits 7:3 |
| base_s | input | 5 | Secondary vector base, vector bits 7:3 |
| eoi | input | 2 | Non-specific end-of-interrupt strobe per controller |
| int_ack | input | 1 | Acknowledge strobe from the processor |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Acknowledged vector |
| vec_valid | output | 1 | Vector valid pulse |

## Verification
The hardest state to reach from the ports is the secondary spurious acknowledge. It needs primary request 2 still latched while the secondary has already lost its winner, and that holds for a single cycle before the drop rule clears it. The stimulus uses a level-triggered secondary line. It lowers the line, waits exactly one edge so that the secondary request is gone but the forwarded request is still set, and then strobes the acknowledge in that cycle. Mask cancellation of a secondary request is made visible by holding a lower primary line pending: the interrupt must fall for one cycle and then come back with that primary line's vector.

// File: rtl/cascade_intc.sv
`timescale 1ns/1ps
module cascade_intc #(
  parameter int          CAS         = 2,
  parameter logic [7:0]  TRIG_MASK_P = 8'hF8,
  parameter logic [7:0]  TRIG_MASK_S = 8'hDE
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] irq_in,
  input  logic [1:0]  mask_we,
  input  logic [7:0]  mask_wdata,
  input  logic [1:0]  trig_we,
  input  logic [7:0]  trig_wdata,
  output logic [7:0]  trig_p,
  output logic [7:0]  trig_s,
  input  logic [4:0]  base_p,
  input  logic [4:0]  base_s,
  input  logic [1:0]  eoi,
  input  logic        int_ack,
  output logic        cpu_int,
  output logic [7:0]  vec_out,
  output logic        vec_valid
);

  function automatic logic [3:0] first_set(input logic [7:0] v);
    first_set = 4'b1000;
    for (int i = 7; i >= 0; i--)
      if (v[i]) first_set = {1'b0, 3'(i)};
  endfunction

  logic [7:0] p_irr, p_imr, p_isr, p_last;
  logic [7:0] s_irr, s_imr, s_isr, s_last;

  logic [7:0] irq_p, irq_s;
  assign irq_p = irq_in[7:0] & ~(8'b1 << CAS);
  assign irq_s = irq_in[15:8];

  logic       p_pn, p_in, s_pn, s_in;
  logic [2:0] p_pi, p_ii, s_pi, s_ii;
  assign {p_pn, p_pi} = first_set(p_irr & ~p_imr);
  assign {p_in, p_ii} = first_set(p_isr);
  assign {s_pn, s_pi} = first_set(s_irr & ~s_imr);
  assign {s_in, s_ii} = first_set(s_isr);

  logic p_has, s_has, p_is_cas;
  assign p_has    = !p_pn && (p_in || (p_pi < p_ii));
  assign s_has    = !s_pn && (s_in || (s_pi < s_ii));
  assign p_is_cas = (p_pi == 3'(CAS));

  logic p_ack, s_ack, drop, cancel_p, cancel_s, raise;
  assign p_ack    = int_ack && p_has;
  assign s_ack    = p_ack && p_is_cas && s_has;
  assign drop     = p_has && p_is_cas && !s_has;
  assign cancel_p = mask_we[0] && p_has && mask_wdata[p_pi];
  assign cancel_s = mask_we[1] && p_has && p_is_cas && s_has && mask_wdata[s_pi];
  assign raise    = p_has && !(p_is_cas && !s_has);

  logic [7:0] p_ack_bit, s_ack_bit, p_eoi_bit, s_eoi_bit;
  assign p_ack_bit = p_ack ? (8'b1 << p_pi) : 8'h00;
  assign s_ack_bit = s_ack ? (8'b1 << s_pi) : 8'h00;
  assign p_eoi_bit = (eoi[0] && !p_in) ? (8'b1 << p_ii) : 8'h00;
  assign s_eoi_bit = (eoi[1] && !s_in) ? (8'b1 << s_ii) : 8'h00;

  logic [7:0] p_irr_n, s_irr_n, p_irr_base;
  assign p_irr_base = (trig_p & irq_p) |
                      (~trig_p & ((p_irr & ~p_ack_bit) | (irq_p & ~p_last)));
  always_comb begin
    p_irr_n      = p_irr_base;
    p_irr_n[CAS] = (p_irr[CAS] | s_has) & ~(p_ack_bit[CAS] | drop | cancel_s);
  end
  assign s_irr_n = (trig_s & irq_s) |
                   (~trig_s & ((s_irr & ~s_ack_bit) | (irq_s & ~s_last)));

  logic [7:0] vec_n;
  always_comb begin
    if (!p_has)        vec_n = {base_p, 3'd7};
    else if (p_is_cas) vec_n = s_has ? {base_s, s_pi} : {base_s, 3'd7};
    else               vec_n = {base_p, p_pi};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_irr <= '0; p_imr <= '0; p_isr <= '0; p_last <= '0;
      s_irr <= '0; s_imr <= '0; s_isr <= '0; s_last <= '0;
      trig_p <= '0; trig_s <= '0;
      cpu_int <= 1'b0; vec_out <= '0; vec_valid <= 1'b0;
    end else begin
      p_last <= irq_p;
      s_last <= irq_s;
      p_irr  <= p_irr_n;
      s_irr  <= s_irr_n;
      p_isr  <= (p_isr | p_ack_bit) & ~p_eoi_bit;
      s_isr  <= (s_isr | s_ack_bit) & ~s_eoi_bit;
      if (mask_we[0]) p_imr <= mask_wdata;
      if (mask_we[1]) s_imr <= mask_wdata;
      if (trig_we[0]) trig_p <= trig_wdata & TRIG_MASK_P;
      if (trig_we[1]) trig_s <= trig_wdata & TRIG_MASK_S;
      cpu_int   <= raise && !cancel_p && !cancel_s && !int_ack;
      vec_valid <= int_ack;
      if (int_ack) vec_out <= vec_n;
    end
  end

  assert_ack_drops_int_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> !cpu_int);
  assert_vec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack |=> vec_valid);
  assert_vec_needs_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(int_ack));
  assert_cascade_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (p_has && p_is_cas && !s_has) |=> !cpu_int);
  assert_mask_cancel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we[0] && p_has && mask_wdata[p_pi]) |=> !cpu_int);
  assert_spurious_primary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_ack && !p_has) |=> (vec_out == {$past(base_p), 3'd7}));
  assert_cascade_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_has && !s_ack && !cancel_s) |=> p_irr[CAS]);

endmodule

// File: tb/tb_cascade_intc.sv
`timescale 1ns/1ps
module tb_cascade_intc;
  logic        clk = 0;
  logic        rst_n;
  logic [15:0] irq_in;
  logic [1:0]  mask_we, trig_we, eoi;
  logic [7:0]  mask_wdata, trig_wdata;
  logic [7:0]  trig_p, trig_s, vec_out;
  logic [4:0]  base_p, base_s;
  logic        int_ack, cpu_int, vec_valid;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] expq[$];

  always #5 clk = ~clk;

  cascade_intc dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
    .mask_we(mask_we), .mask_wdata(mask_wdata),
    .trig_we(trig_we), .trig_wdata(trig_wdata),
    .trig_p(trig_p), .trig_s(trig_s),
    .base_p(base_p), .base_s(base_s), .eoi(eoi),
    .int_ack(int_ack), .cpu_int(cpu_int),
    .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] exp);
    expq.push_back(exp);
    int_ack = 1;
    step(1);
    int_ack = 0;
    chk(cpu_int == 0, "R9 int low after ack", cpu_int, 0);
  endtask

  task automatic pulse(input int line);
    irq_in[line] = 1;
    step(1);
    irq_in[line] = 0;
  endtask

  task automatic end_irq(input logic [1:0] which);
    eoi = which;
    step(1);
    eoi = 0;
  endtask

  task automatic mask_wr(input logic [1:0] which, input logic [7:0] d);
    mask_we = which; mask_wdata = d;
    step(1);
    mask_we = 0;
  endtask

  task automatic trig_wr(input logic [1:0] which, input logic [7:0] d);
    trig_we = which; trig_wdata = d;
    step(1);
    trig_we = 0;
  endtask

  // scoreboard monitor: every vector pulse is matched against the queue
  always @(negedge clk) begin
    if (vec_valid) begin
      if (expq.size() == 0) chk(0, "R9 unexpected vector", vec_out, 0);
      else begin
        logic [7:0] e;
        e = expq.pop_front();
        chk(vec_out == e, "R2/R5/R7 vector", vec_out, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; irq_in = 0; mask_we = 0; trig_we = 0; eoi = 0; int_ack = 0;
    mask_wdata = 0; trig_wdata = 0; base_p = 5'h01; base_s = 5'h0E;
    step(3);
    rst_n = 1;
    step(1);
    // R1
    chk(cpu_int == 0, "R1 cpu_int", cpu_int, 0);
    chk(vec_valid == 0, "R1 vec_valid", vec_valid, 0);
    chk(trig_p == 0 && trig_s == 0, "R1 trigger regs", {trig_p, trig_s}, 0);
    step(3);
    chk(cpu_int == 0, "R1 idle", cpu_int, 0);

    // R2 edge line 3
    pulse(3); step(1);
    chk(cpu_int == 1, "R2 raise", cpu_int, 1);
    ack(8'h0B);
    end_irq(2'b01); step(2);
    chk(cpu_int == 0, "R2 edge cleared by ack", cpu_int, 0);

    // R10 priority and nesting
    irq_in[4] = 1; irq_in[6] = 1; step(1); irq_in[4] = 0; irq_in[6] = 0; step(1);
    chk(cpu_int == 1, "R2 two lines", cpu_int, 1);
    ack(8'h0C);
    step(3);
    chk(cpu_int == 0, "R10 lower line blocked", cpu_int, 0);
    end_irq(2'b01); step(1);
    chk(cpu_int == 1, "R10 eoi releases", cpu_int, 1);
    ack(8'h0E);
    end_irq(2'b01);

    // R5 cascade
    pulse(2); step(3);
    chk(cpu_int == 0, "R5 input line 2 ignored", cpu_int, 0);
    pulse(11); step(2);
    chk(cpu_int == 1, "R5 forwarded", cpu_int, 1);
    ack(8'h73);
    end_irq(2'b11); step(3);
    chk(cpu_int == 0, "R5 both acked", cpu_int, 0);

    // R4 trigger select
    trig_wr(2'b01, 8'hFF);
    chk(trig_p == 8'hF8, "R4 primary mask", trig_p, 8'hF8);
    trig_wr(2'b10, 8'hFF);
    chk(trig_s == 8'hDE, "R4 secondary mask", trig_s, 8'hDE);
    trig_wr(2'b01, 8'h27);
    chk(trig_p == 8'h20, "R4 primary store", trig_p, 8'h20);
    trig_wr(2'b10, 8'h05);
    chk(trig_s == 8'h04, "R4 secondary store", trig_s, 8'h04);

    // R3 level line 5
    irq_in[5] = 1; step(2);
    chk(cpu_int == 1, "R3 level raise", cpu_int, 1);
    ack(8'h0D);
    end_irq(2'b01); step(1);
    chk(cpu_int == 1, "R3 level kept after ack", cpu_int, 1);
    ack(8'h0D);
    end_irq(2'b01);
    irq_in[5] = 0; step(2);
    chk(cpu_int == 0, "R3 level follows line", cpu_int, 0);

    // R6 drop of stale cascade request
    irq_in[10] = 1; irq_in[6] = 1; step(1); irq_in[6] = 0; step(3);
    chk(cpu_int == 1, "R6 setup", cpu_int, 1);
    irq_in[10] = 0; step(2);
    chk(cpu_int == 0, "R6 stale cascade not raised", cpu_int, 0);
    step(1);
    chk(cpu_int == 1, "R6 lower line served", cpu_int, 1);
    ack(8'h0E);
    end_irq(2'b01);

    // R7 spurious secondary, then spurious primary
    irq_in[10] = 1; step(4);
    chk(cpu_int == 1, "R7 setup", cpu_int, 1);
    irq_in[10] = 0; step(1);
    ack(8'h77);
    end_irq(2'b01); step(2);
    chk(cpu_int == 0, "R7 quiet", cpu_int, 0);
    ack(8'h0F);

    // R8 primary mask cancel
    pulse(4); step(1);
    chk(cpu_int == 1, "R8 setup primary", cpu_int, 1);
    mask_wr(2'b01, 8'h10);
    chk(cpu_int == 0, "R8 primary cancel", cpu_int, 0);
    step(2);
    chk(cpu_int == 0, "R8 stays masked", cpu_int, 0);
    mask_wr(2'b01, 8'h00); step(1);
    chk(cpu_int == 1, "R8 unmask returns", cpu_int, 1);
    ack(8'h0C);
    end_irq(2'b01);

    // R8 secondary mask cancel with lower primary line waiting
    irq_in[5] = 1; irq_in[9] = 1; step(1); irq_in[9] = 0; step(2);
    chk(cpu_int == 1, "R8 setup secondary", cpu_int, 1);
    mask_wr(2'b10, 8'h02);
    chk(cpu_int == 0, "R8 secondary cancel", cpu_int, 0);
    step(1);
    chk(cpu_int == 1, "R8 primary line next", cpu_int, 1);
    ack(8'h0D);
    irq_in[5] = 0;
    end_irq(2'b01);
    mask_wr(2'b10, 8'h00); step(2);
    chk(cpu_int == 1, "R8 secondary unmasked", cpu_int, 1);
    ack(8'h71);
    end_irq(2'b11);

    step(5);
    chk(expq.size() == 0, "R9 every ack gave a vector", expq.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule